// File: doc/BRIEF.md
# Effective address sequencer

This block turns the addressing fields of a decoded instruction into the value that the execute stage needs. It takes a 16-bit address field, a register selector, a 4-bit mode code, a nesting level and the current program counter. It returns either an effective address or, for the immediate and register modes, the operand value itself. A one-cycle `done` pulse and the `is_value` flag come with the result. Modes that need no memory finish in the cycle after the request.

Modes that dereference pointers drive a synchronous memory read port. That port returns data one cycle after the request. The block walks the pointer chain with a small state machine, and each read takes a request cycle and a wait cycle. A combinational register file read port supplies the register contents. The register selector goes straight to that port, and the value is captured when the request is accepted.

Top module: `ea_sequencer`

## Requirements
- R1: Mode 0 (immediate) returns the address field as the result with `is_value`=1. It makes no memory read, and `done` is high in the cycle after `start` is accepted.
- R2: Mode 1 (direct) returns the address field with `is_value`=0, and `done` is high in the cycle after acceptance.
- R3: Mode 3 returns the selected register's contents with `is_value`=1. Mode 4 returns the same contents as an address with `is_value`=0. Both finish in the cycle after acceptance.
- R4: Mode 5 returns the address field plus the register contents, and mode 6 returns the address field plus the PC. Both sums are taken modulo 2^16, have `is_value`=0 and finish in the cycle after acceptance.
- R5: Mode 2 (pointer chain) performs `level`+1 reads, where `level` runs from 0 to 3. The first read is at the address field, and each later read is at the word returned by the read before it. The result is the last word read, and `done` is high 2·(`level`+1)+1 cycles after the start cycle.
- R6: Mode 8 reads once at the address field and returns that word plus the register contents. `done` is high 3 cycles after the start cycle.
- R7: Mode 7 reads once at the address field plus the register contents and returns the word read. `done` is high 3 cycles after the start cycle.
- R8: `mem_re` is high for exactly one cycle per read, starting in the cycle after acceptance, and is low in the wait cycle that follows each read. `mem_addr` carries the read address while `mem_re` is high.
- R9: `busy` is high from the first read cycle through the last wait cycle. A `start` during those cycles is ignored and produces no `done`, `err` or read.
- R10: Mode codes 9 to 15 give a one-cycle `err` pulse in the cycle after acceptance, with no `done` and no memory read.
- R11: While `rst_n` is low, `done`, `err`, `busy` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, sampled when idle |
| mode | input | 4 | Addressing mode code |
| level | input | 2 | Pointer chain depth minus one (mode 2) |
| addr_a | input | 16 | Instruction address field |
| reg_sel | input | 3 | Register selector |
| pc | input | 16 | Current program counter |
| rf_raddr | output | 3 | Register file read address |
| rf_rdata | input | 16 | Register file read data (combinational) |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, valid one cycle after request |
| busy | output | 1 | A pointer sequence is in progress |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Unsupported mode pulse |
| is_value | output | 1 | Result is an operand value rather than an address |
| result | output | 16 | Effective address or operand value |

## Verification
Results of the register, immediate, direct, displacement and PC-relative modes are due in the cycle after the start cycle. A sequence with n memory reads completes in cycle 2n+1, with its reads in cycles 1, 3, ... 2n-1 and `busy` set over cycles 1 to 2n. The error pulse is due in cycle 1. The reference model stores the exact cycle number of each expected event and compares every output on each falling edge. An output that appears one cycle early or one cycle late therefore fails both the cycle where it was expected and the cycle where it actually showed up.

// File: rtl/ea_pkg.sv
// Shared types for the effective address sequencer.
// Assumes a 4-bit mode code; codes above MD_POSTIDX are unsupported.
package ea_pkg;

    typedef enum logic [3:0] {
        MD_IMM     = 4'd0,
        MD_DIR     = 4'd1,
        MD_CHAIN   = 4'd2,
        MD_REG     = 4'd3,
        MD_REGPTR  = 4'd4,
        MD_DISP    = 4'd5,
        MD_PCREL   = 4'd6,
        MD_PREIDX  = 4'd7,
        MD_POSTIDX = 4'd8
    } ea_mode_e;

    typedef enum logic [1:0] {
        SRC_A,
        SRC_REG,
        SRC_A_REG,
        SRC_A_PC
    } ea_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WT
    } ea_state_e;

    typedef struct packed {
        logic    valid;
        logic    uses_mem;
        logic    nested;
        logic    is_value;
        logic    add_after;
        ea_src_e src;
    } ea_ctrl_t;

endpackage

// File: rtl/ea_mode_decode.sv
// Mode decoder: maps the 4-bit mode code to control fields.
// Purely combinational; assumes the code is stable while start is high.
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [3:0] mode,
    output ea_ctrl_t   ctrl
);

    // Translate the mode code into datapath and sequencing controls.
    always_comb begin
        ctrl = '{valid: 1'b1, uses_mem: 1'b0, nested: 1'b0,
                 is_value: 1'b0, add_after: 1'b0, src: SRC_A};
        case (mode)
            MD_IMM:     ctrl.is_value = 1'b1;
            MD_DIR:     ctrl.src = SRC_A;
            MD_CHAIN: begin
                ctrl.uses_mem = 1'b1;
                ctrl.nested   = 1'b1;
            end
            MD_REG: begin
                ctrl.src      = SRC_REG;
                ctrl.is_value = 1'b1;
            end
            MD_REGPTR:  ctrl.src = SRC_REG;
            MD_DISP:    ctrl.src = SRC_A_REG;
            MD_PCREL:   ctrl.src = SRC_A_PC;
            MD_PREIDX: begin
                ctrl.uses_mem = 1'b1;
                ctrl.src      = SRC_A_REG;
            end
            MD_POSTIDX: begin
                ctrl.uses_mem  = 1'b1;
                ctrl.add_after = 1'b1;
            end
            default:    ctrl.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/ea_addr_unit.sv
// Address former: selects the field, register value, or one of two
// modulo-2^W sums. Combinational; inputs come straight from the request.
module ea_addr_unit
    import ea_pkg::*;
#(
    parameter int W = 16
) (
    input  ea_src_e        src,
    input  logic [W-1:0]   addr_a,
    input  logic [W-1:0]   rval,
    input  logic [W-1:0]   pc,
    output logic [W-1:0]   formed
);

    // Pick or add the operands named by the source select.
    always_comb begin
        case (src)
            SRC_A:     formed = addr_a;
            SRC_REG:   formed = rval;
            SRC_A_REG: formed = addr_a + rval;
            SRC_A_PC:  formed = addr_a + pc;
            default:   formed = addr_a;
        endcase
    end

endmodule

// File: rtl/ea_seq_fsm.sv
// Pointer read sequencer: accepts a request when idle, finishes
// non-memory modes at once, and otherwise issues reads, each followed by
// a wait cycle. Assumes memory data is valid in the cycle after mem_re.
module ea_seq_fsm
    import ea_pkg::*;
#(
    parameter int W     = 16,
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  ea_ctrl_t         ctrl,
    input  logic [LVL_W-1:0] level,
    input  logic [W-1:0]     formed,
    input  logic [W-1:0]     rval,
    input  logic [W-1:0]     mem_rdata,
    output logic             mem_re,
    output logic [W-1:0]     mem_addr,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             is_value,
    output logic [W-1:0]     result
);

    ea_state_e        state_q;
    logic [W-1:0]     ptr_q;
    logic [LVL_W-1:0] left_q;
    logic [W-1:0]     rval_q;
    logic             add_after_q;
    logic [W-1:0]     result_q;
    logic             done_q;
    logic             err_q;
    logic             isval_q;
    logic             accept;

    assign accept = start && (state_q == ST_IDLE);

    // Sequencing state, pointer walk and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ptr_q       <= '0;
            left_q      <= '0;
            rval_q      <= '0;
            add_after_q <= 1'b0;
            result_q    <= '0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            isval_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (!ctrl.valid) begin
                            err_q <= 1'b1;
                        end else if (!ctrl.uses_mem) begin
                            result_q <= formed;
                            isval_q  <= ctrl.is_value;
                            done_q   <= 1'b1;
                        end else begin
                            ptr_q       <= formed;
                            left_q      <= ctrl.nested ? level : '0;
                            rval_q      <= rval;
                            add_after_q <= ctrl.add_after;
                            state_q     <= ST_RD;
                        end
                    end
                end
                ST_RD: state_q <= ST_WT;
                ST_WT: begin
                    if (left_q != '0) begin
                        ptr_q   <= mem_rdata;
                        left_q  <= left_q - 1'b1;
                        state_q <= ST_RD;
                    end else begin
                        result_q <= add_after_q ? (mem_rdata + rval_q) : mem_rdata;
                        isval_q  <= 1'b0;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_re   = (state_q == ST_RD);
    assign mem_addr = ptr_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign is_value = isval_q;
    assign result   = result_q;

endmodule

// File: rtl/ea_sequencer.sv
// Effective address sequencer top: decodes the mode, forms the address
// or operand, and sequences pointer reads. Assumes a combinational
// register file read port and a one-cycle-latency memory read port.
module ea_sequencer
    import ea_pkg::*;
#(
    parameter int W      = 16,
    parameter int NREG   = 8,
    parameter int LVL_W  = 2,
    localparam int RSEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [LVL_W-1:0]  level,
    input  logic [W-1:0]      addr_a,
    input  logic [RSEL_W-1:0] reg_sel,
    input  logic [W-1:0]      pc,
    output logic [RSEL_W-1:0] rf_raddr,
    input  logic [W-1:0]      rf_rdata,
    output logic              mem_re,
    output logic [W-1:0]      mem_addr,
    input  logic [W-1:0]      mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              is_value,
    output logic [W-1:0]      result
);

    ea_ctrl_t     ctrl;
    logic [W-1:0] formed;

    assign rf_raddr = reg_sel;

    ea_mode_decode u_dec (
        .mode (mode),
        .ctrl (ctrl)
    );

    ea_addr_unit #(.W(W)) u_addr (
        .src    (ctrl.src),
        .addr_a (addr_a),
        .rval   (rf_rdata),
        .pc     (pc),
        .formed (formed)
    );

    ea_seq_fsm #(.W(W), .LVL_W(LVL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ctrl      (ctrl),
        .level     (level),
        .formed    (formed),
        .rval      (rf_rdata),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .is_value  (is_value),
        .result    (result)
    );

endmodule

// File: rtl/ea_sequencer_chk.sv
// Protocol checker for ea_sequencer, bound to every instance of the top.
// Assumes the register file read data is stable within a cycle.
module ea_sequencer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [3:0]   mode,
    input logic [W-1:0] addr_a,
    input logic [W-1:0] rf_rdata,
    input logic         mem_re,
    input logic         busy,
    input logic         done,
    input logic         err,
    input logic         is_value,
    input logic [W-1:0] result
);

    p_imm_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd0) |=> (done && is_value && result == $past(addr_a)));

    p_direct_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd1) |=> (done && !is_value && result == $past(addr_a)));

    p_reg_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd3) |=> (done && is_value && result == $past(rf_rdata)));

    p_disp_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd5) |=> (done && result == W'($past(addr_a) + $past(rf_rdata))));

    p_read_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    p_read_in_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> busy);

    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !err));

    p_bad_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode > 4'd8) |=> (err && !done && !busy));

    p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

bind ea_sequencer ea_sequencer_chk #(.W(W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .addr_a   (addr_a),
    .rf_rdata (rf_rdata),
    .mem_re   (mem_re),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .is_value (is_value),
    .result   (result)
);

// File: tb/test_ea_sequencer.sv
module test_ea_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  level = '0;
    logic [15:0] addr_a = '0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] pc = '0;
    logic [2:0]  rf_raddr;
    logic [15:0] rf_rdata;
    logic        mem_re;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        busy, done, err, is_value;
    logic [15:0] result;

    logic [15:0] rf [8];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_cyc = -1;
    logic exp_err = 1'b0;
    logic exp_isval = 1'b0;
    logic [15:0] exp_res = '0;
    string exp_tag = "";
    int blo = 1;
    int bhi = 0;
    int rd_cyc[$];
    logic [15:0] rd_addr[$];

    always #5 clk = ~clk;

    ea_sequencer i_ea_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .level(level),
        .addr_a(addr_a), .reg_sel(reg_sel), .pc(pc), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err),
        .is_value(is_value), .result(result)
    );

    assign rf_rdata = rf[rf_raddr];

    function automatic logic [15:0] memf(input logic [15:0] a);
        return (a ^ 16'h5A5A) + 16'h0123;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_re) mem_rdata <= memf(mem_addr);
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, got, want, cyc);
        end
    endtask

    task automatic check_now();
        if (!rst_n) begin
            chk(!done && !err && !busy && !mem_re, "R11", "outputs in reset",
                {12'h0, done, err, busy, mem_re}, 16'h0);
            return;
        end
        if (cyc == exp_cyc) begin
            if (exp_err)
                chk(err && !done, exp_tag, "err pulse", {14'h0, err, done}, 16'h2);
            else begin
                chk(done && !err, exp_tag, "done pulse", {14'h0, done, err}, 16'h2);
                chk(result == exp_res, exp_tag, "result", result, exp_res);
                chk(is_value == exp_isval, exp_tag, "is_value", {15'h0, is_value}, {15'h0, exp_isval});
            end
        end else begin
            chk(!done && !err, "R9", "no stray done/err", {14'h0, done, err}, 16'h0);
        end
        if (rd_cyc.size() > 0 && rd_cyc[0] == cyc) begin
            chk(mem_re == 1'b1, "R8", "read strobe", {15'h0, mem_re}, 16'h1);
            chk(mem_addr == rd_addr[0], "R8", "read address", mem_addr, rd_addr[0]);
            void'(rd_cyc.pop_front());
            void'(rd_addr.pop_front());
        end else begin
            chk(mem_re == 1'b0, "R8", "no read", {15'h0, mem_re}, 16'h0);
        end
        chk(busy == (cyc >= blo && cyc <= bhi), "R9", "busy",
            {15'h0, busy}, {15'h0, (cyc >= blo && cyc <= bhi)});
    endtask

    task automatic tick();
        @(negedge clk);
        check_now();
    endtask

    task automatic issue(input logic [3:0] m, input logic [1:0] lv,
                         input logic [15:0] a, input logic [2:0] r, input string tag);
        int c = cyc;
        int lat = 1;
        int nrd = 0;
        logic [15:0] p;
        if (!(c >= blo && c <= bhi)) begin
            exp_err = 1'b0;
            exp_isval = 1'b0;
            exp_tag = tag;
            case (m)
                4'd0: begin exp_res = a; exp_isval = 1'b1; end
                4'd1: exp_res = a;
                4'd3: begin exp_res = rf[r]; exp_isval = 1'b1; end
                4'd4: exp_res = rf[r];
                4'd5: exp_res = a + rf[r];
                4'd6: exp_res = a + pc;
                4'd2: begin
                    p = a;
                    nrd = int'(lv) + 1;
                    for (int k = 0; k < nrd; k++) begin
                        rd_cyc.push_back(c + 1 + 2 * k);
                        rd_addr.push_back(p);
                        p = memf(p);
                    end
                    exp_res = p;
                end
                4'd7: begin
                    nrd = 1;
                    p = a + rf[r];
                    rd_cyc.push_back(c + 1);
                    rd_addr.push_back(p);
                    exp_res = memf(p);
                end
                4'd8: begin
                    nrd = 1;
                    rd_cyc.push_back(c + 1);
                    rd_addr.push_back(a);
                    exp_res = memf(a) + rf[r];
                end
                default: exp_err = 1'b1;
            endcase
            lat = 2 * nrd + 1;
            exp_cyc = c + lat;
            if (nrd > 0) begin blo = c + 1; bhi = c + 2 * nrd; end
        end
        start = 1'b1; mode = m; level = lv; addr_a = a; reg_sel = r;
        tick();
        start = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 16'h1111 * i + 16'h0020;
        pc = 16'h8000;
        settle(3);
        rst_n = 1'b1;
        tick();
        // R1 immediate, then R2 direct back to back in the done cycle
        issue(4'd0, 2'd0, 16'hBEEF, 3'd0, "R1");
        issue(4'd1, 2'd0, 16'h1234, 3'd0, "R2");
        settle(2);
        // R3 register value and register pointer
        issue(4'd3, 2'd0, 16'h0000, 3'd5, "R3");
        issue(4'd4, 2'd0, 16'h0000, 3'd2, "R3");
        settle(2);
        // R4 displacement with wraparound, PC-relative with wraparound
        rf[1] = 16'h0020;
        issue(4'd5, 2'd0, 16'hFFF0, 3'd1, "R4");
        issue(4'd6, 2'd0, 16'h9000, 3'd0, "R4");
        settle(2);
        // R5 pointer chain, all four depths
        for (int lv = 0; lv < 4; lv++) begin
            issue(4'd2, 2'(lv), 16'h0100 + 16'(lv), 3'd0, "R5");
            settle(2 * (lv + 1) + 1);
        end
        // R6 post-index and R7 pre-index
        issue(4'd8, 2'd3, 16'h0400, 3'd6, "R6");
        settle(4);
        issue(4'd7, 2'd3, 16'h0400, 3'd6, "R7");
        settle(4);
        // R10 unsupported codes
        issue(4'd9, 2'd0, 16'h0001, 3'd0, "R10");
        issue(4'd15, 2'd0, 16'h0002, 3'd0, "R10");
        settle(2);
        // R9 start while busy is ignored (immediate, bad code, chain)
        issue(4'd2, 2'd3, 16'h0777, 3'd0, "R5");
        issue(4'd0, 2'd0, 16'hAAAA, 3'd0, "R9");
        issue(4'd12, 2'd0, 16'h0000, 3'd0, "R9");
        settle(3);
        issue(4'd2, 2'd1, 16'h0055, 3'd0, "R9");
        settle(6);
        issue(4'd0, 2'd0, 16'h0F0F, 3'd0, "R1");
        settle(3);
        // R11 reset mid-sequence clears outputs
        issue(4'd2, 2'd3, 16'h0300, 3'd0, "R5");
        rst_n = 1'b0;
        rd_cyc.delete(); rd_addr.delete();
        exp_cyc = -1; blo = 1; bhi = 0;
        settle(3);
        rst_n = 1'b1;
        settle(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule